// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block gathers the interrupt conditions of a CAN controller into readable flag bits, masks them with a software-written enable register, and drives one interrupt request towards the CPU. Along with the request it reports a 3-bit dispatch code that names the most urgent pending source, so a handler can branch through a jump table instead of scanning the flags.

There are eight main interrupts. Index 0 is the error interrupt. Indices 1 to 3 are the three transmit buffers. Indices 4 and 5 are the two receive buffers. Index 6 is bus wake-up and index 7 is invalid message. Seven of the main flags are stored directly. The error flag is not stored: it reads as the OR of six separately stored error sub-flags. Sub-flag 0 is receiver overrun, 1 receiver warning, 2 receiver error-passive, 3 transmitter warning, 4 transmitter error-passive and 5 bus-off.

A flag is set by a one-cycle event pulse and is cleared by a write-one-to-clear strobe. Most flags also have a level input that reports that their cause still holds. While that level is high, a clear is refused. Sub-flags 1 to 5 come from error-counter thresholds and clear whatever their level input shows.

Each stored flag is a two-state machine. In state FLAG_IDLE an event moves it to FLAG_PEND (transition "set"). In FLAG_PEND a clear moves it back to FLAG_IDLE (transition "accepted clear"), unless the cause still holds and the flag is not exempt (transition "refused clear", stay in FLAG_PEND). An event in the same cycle keeps it in FLAG_PEND (transition "set wins").

Top module: `canirq_unit`

## Requirements
- R1: After reset every flag, every error sub-flag and the enable register read 0, the request is low and the code is 0.
- R2: An event pulse on a main source (index 1 to 7) makes its flag read 1 from the next cycle on, and it stays 1 while no accepted clear arrives.
- R3: A clear strobe on a set main flag makes it read 0 in the next cycle when its hold level is low. When its hold level is high, the flag stays 1.
- R4: When an event and a clear reach the same flag in one cycle, the flag reads 1 afterwards.
- R5: Each error sub-source sets its own sub-flag on its event pulse. Main flag bit 0 reads 1 exactly when any sub-flag is 1.
- R6: Sub-flags 1 to 5 clear on a clear strobe regardless of their hold level. Sub-flag 0 (overrun) keeps the R3 rule and refuses a clear while its hold level is high.
- R7: A write strobe loads the enable register, which reads back the written value from the next cycle on.
- R8: The interrupt request is high exactly when some main flag and its enable bit are both 1.
- R9: The code is 0 when nothing is both flagged and enabled. Otherwise it names the lowest index among flagged-and-enabled interrupts as index+1, so error is 1, the transmit buffers are 2 to 4 and the receive buffers are 5 and 6. Wake-up (index 6) and invalid message (index 7) both report 7.
- R10: A flag whose enable bit is 0 still sets and reads back, but it does not raise the request or change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_ev_i | input | 7 | Event pulses for main interrupts 1..7 (bit k-1 is index k) |
| main_hold_i | input | 7 | Cause-still-present levels for main interrupts 1..7 |
| err_ev_i | input | 6 | Event/threshold pulses for the six error sub-sources |
| err_hold_i | input | 6 | Cause-still-present levels for the error sub-sources |
| clr_main_i | input | 7 | Write-one-to-clear strobes for main flags 1..7 |
| clr_err_i | input | 6 | Write-one-to-clear strobes for error sub-flags |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| flags_o | output | 8 | Main flag readback; bit 0 is the error summary |
| err_flags_o | output | 6 | Error sub-flag readback |
| en_o | output | 8 | Enable register readback |
| irq_o | output | 1 | Interrupt request |
| code_o | output | 3 | Dispatch code of the most urgent pending interrupt |

## Verification
The assertions assume that event, clear and write strobes are sampled only on rising clock edges and that every input is held at a known value while reset is released. They also assume that hold levels describe the cause as seen in the same cycle as a clear. The stimulus drives every input only at falling edges. During reset it keeps all strobes at zero. It raises hold levels independently of events, including on the exempt threshold sub-flags, so both outcomes of a clear are visited. A long sparse random phase then mixes events, clears, holds and enable writes, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    localparam int unsigned MAIN_COUNT  = 8;
    localparam int unsigned ERR_COUNT   = 6;
    localparam int unsigned CODE_BITS   = 3;

    localparam logic [ERR_COUNT-1:0] THRESH_EXEMPT = 6'b111110;

endpackage

// File: rtl/canirq_flag_cell.sv
module canirq_flag_cell
    import canirq_pkg::*;
#(
    parameter bit EXEMPT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        clr_ok;

    // a clear is accepted when the flag is exempt or the cause is gone
    always_comb begin
        clr_ok = clr_i && (EXEMPT || !hold_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) begin
                    state_d = FLAG_PEND;
                end
            end
            FLAG_PEND: begin
                if (set_i) begin
                    state_d = FLAG_PEND;
                end else if (clr_ok) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_o = (state_q == FLAG_PEND);
    end

endmodule

// File: rtl/canirq_prio.sv
module canirq_prio #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 3
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o,
    output logic          any_o
);

    localparam int unsigned MAXC = (1 << CW) - 1;

    always_comb begin
        code_o = '0;
        any_o  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                any_o = 1'b1;
                if (i + 1 >= MAXC) begin
                    code_o = CW'(MAXC);
                end else begin
                    code_o = CW'(i + 1);
                end
            end
        end
    end

endmodule

// File: rtl/canirq_enable_reg.sv
module canirq_enable_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we_i) begin
            en_q <= wdata_i;
        end
    end

    always_comb begin
        en_o = en_q;
    end

endmodule

// File: rtl/canirq_unit.sv
module canirq_unit
    import canirq_pkg::*;
#(
    parameter int unsigned           NMAIN  = MAIN_COUNT,
    parameter int unsigned           NERR   = ERR_COUNT,
    parameter int unsigned           CW     = CODE_BITS,
    parameter logic [ERR_COUNT-1:0]  EXEMPT = THRESH_EXEMPT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NMAIN-2:0] main_ev_i,
    input  logic [NMAIN-2:0] main_hold_i,
    input  logic [NERR-1:0]  err_ev_i,
    input  logic [NERR-1:0]  err_hold_i,
    input  logic [NMAIN-2:0] clr_main_i,
    input  logic [NERR-1:0]  clr_err_i,
    input  logic             en_we_i,
    input  logic [NMAIN-1:0] en_wdata_i,
    output logic [NMAIN-1:0] flags_o,
    output logic [NERR-1:0]  err_flags_o,
    output logic [NMAIN-1:0] en_o,
    output logic             irq_o,
    output logic [CW-1:0]    code_o
);

    localparam int unsigned NSTORED = NMAIN - 1;

    logic [NSTORED-1:0] main_flags;
    logic [NERR-1:0]    err_flags;
    logic [NMAIN-1:0]   en_q;
    logic [NMAIN-1:0]   pend;
    logic               any_pend;

    for (genvar k = 0; k < NSTORED; k++) begin : g_main
        canirq_flag_cell #(.EXEMPT(1'b0)) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (main_ev_i[k]),
            .hold_i (main_hold_i[k]),
            .clr_i  (clr_main_i[k]),
            .flag_o (main_flags[k])
        );
    end

    for (genvar j = 0; j < NERR; j++) begin : g_err
        canirq_flag_cell #(.EXEMPT(EXEMPT[j])) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (err_ev_i[j]),
            .hold_i (err_hold_i[j]),
            .clr_i  (clr_err_i[j]),
            .flag_o (err_flags[j])
        );
    end

    canirq_enable_reg #(.N(NMAIN)) en_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_q)
    );

    always_comb begin
        pend = {main_flags, |err_flags} & en_q;
    end

    canirq_prio #(.N(NMAIN), .CW(CW)) prio_i (
        .pend_i (pend),
        .code_o (code_o),
        .any_o  (any_pend)
    );

    always_comb begin
        flags_o     = {main_flags, |err_flags};
        err_flags_o = err_flags;
        en_o        = en_q;
        irq_o       = |pend;
    end

endmodule

// File: rtl/canirq_unit_chk.sv
module canirq_unit_chk #(
    parameter int unsigned NMAIN  = 8,
    parameter int unsigned NERR   = 6,
    parameter int unsigned CW     = 3,
    parameter logic [5:0]  EXEMPT = 6'b111110
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NMAIN-2:0] main_ev_i,
    input logic [NMAIN-2:0] main_hold_i,
    input logic [NERR-1:0]  err_ev_i,
    input logic [NERR-1:0]  err_hold_i,
    input logic [NMAIN-2:0] clr_main_i,
    input logic [NERR-1:0]  clr_err_i,
    input logic             en_we_i,
    input logic [NMAIN-1:0] en_wdata_i,
    input logic [NMAIN-1:0] flags_o,
    input logic [NERR-1:0]  err_flags_o,
    input logic [NMAIN-1:0] en_o,
    input logic             irq_o,
    input logic [CW-1:0]    code_o
);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|main_ev_i) |=>
        ((flags_o[NMAIN-1:1] & $past(main_ev_i)) == $past(main_ev_i)));

    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_main_i & main_hold_i & flags_o[NMAIN-1:1])) |=>
        ((flags_o[NMAIN-1:1] & $past(clr_main_i & main_hold_i & flags_o[NMAIN-1:1]))
            == $past(clr_main_i & main_hold_i & flags_o[NMAIN-1:1])));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_main_i & ~main_hold_i & ~main_ev_i)) |=>
        ((flags_o[NMAIN-1:1] & $past(clr_main_i & ~main_hold_i & ~main_ev_i)) == '0));

    p_setwins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_ev_i & clr_err_i)) |=>
        ((err_flags_o & $past(err_ev_i & clr_err_i)) == $past(err_ev_i & clr_err_i)));

    p_errsum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_ev_i) |=> flags_o[0]);

    p_exempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_err_i & EXEMPT[NERR-1:0] & ~err_ev_i)) |=>
        ((err_flags_o & $past(clr_err_i & EXEMPT[NERR-1:0] & ~err_ev_i)) == '0));

    p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(en_wdata_i)));

    p_code_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (code_o != '0));

endmodule

bind canirq_unit canirq_unit_chk #(
    .NMAIN  (NMAIN),
    .NERR   (NERR),
    .CW     (CW),
    .EXEMPT (EXEMPT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_ev_i   (main_ev_i),
    .main_hold_i (main_hold_i),
    .err_ev_i    (err_ev_i),
    .err_hold_i  (err_hold_i),
    .clr_main_i  (clr_main_i),
    .clr_err_i   (clr_err_i),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .flags_o     (flags_o),
    .err_flags_o (err_flags_o),
    .en_o        (en_o),
    .irq_o       (irq_o),
    .code_o      (code_o)
);

// File: tb/canirq_unit_tb_top.sv
module canirq_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] main_ev, main_hold, clr_main;
    logic [5:0] err_ev, err_hold, clr_err;
    logic       en_we;
    logic [7:0] en_wdata;
    logic [7:0] flags;
    logic [5:0] err_flags;
    logic [7:0] en;
    logic       irq;
    logic [2:0] code;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // behavioural reference state
    logic [6:0] m_main = '0;
    logic [5:0] m_err  = '0;
    logic [7:0] m_en   = '0;
    localparam logic [5:0] EXM = 6'b111110;

    always #4 clk = ~clk;

    canirq_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .main_ev_i(main_ev), .main_hold_i(main_hold),
        .err_ev_i(err_ev), .err_hold_i(err_hold),
        .clr_main_i(clr_main), .clr_err_i(clr_err),
        .en_we_i(en_we), .en_wdata_i(en_wdata),
        .flags_o(flags), .err_flags_o(err_flags), .en_o(en),
        .irq_o(irq), .code_o(code)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] ef;
        logic [7:0] pend;
        int         ec;
        ef   = {m_main, |m_err};
        pend = ef & m_en;
        ec   = 0;
        for (int i = 7; i >= 0; i--) begin
            if (pend[i]) ec = (i + 1 > 7) ? 7 : i + 1;
        end
        chk(tag, "flags", flags, ef);
        chk(tag, "err_flags", err_flags, m_err);
        chk(tag, "enable", en, m_en);
        chk("R8", "irq", irq, (pend != 0) ? 1 : 0);
        chk("R9", "code", code, ec);
    endtask

    task automatic idle_strobes();
        main_ev  = '0;
        err_ev   = '0;
        clr_main = '0;
        clr_err  = '0;
        en_we    = 1'b0;
        en_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        for (int k = 0; k < 7; k++) begin
            if (main_ev[k]) m_main[k] = 1'b1;
            else if (clr_main[k] && !main_hold[k]) m_main[k] = 1'b0;
        end
        for (int j = 0; j < 6; j++) begin
            if (err_ev[j]) m_err[j] = 1'b1;
            else if (clr_err[j] && (EXM[j] || !err_hold[j])) m_err[j] = 1'b0;
        end
        if (en_we) m_en = en_wdata;
        @(negedge clk);
        compare();
        idle_strobes();
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        main_hold = '0;
        err_hold  = '0;
        idle_strobes();
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;

        tag = "R7"; en_we = 1'b1; en_wdata = 8'hA5; step();
        en_we = 1'b1; en_wdata = 8'hFF; step();

        tag = "R2"; main_ev = 7'b0000101; step();
        step();

        tag = "R3"; main_hold = 7'b0000001; clr_main = 7'b0000101; step();
        main_hold = '0; clr_main = 7'b0000001; step();

        tag = "R4"; main_ev = 7'b0001000; clr_main = 7'b0001000; step();

        tag = "R5"; err_ev = 6'b100100; step();

        tag = "R6"; err_hold = 6'b111111; err_ev = 6'b000001; step();
        clr_err = 6'b111111; step();
        err_hold = '0; clr_err = 6'b000001; step();

        tag = "R10"; en_we = 1'b1; en_wdata = 8'h00; step();
        main_ev = 7'h7F; err_ev = 6'b000010; step();
        en_we = 1'b1; en_wdata = 8'hFF; step();

        tag = "R9";
        clr_err = 6'h3F; step();
        for (int i = 0; i < 7; i++) begin
            clr_main = 7'(1 << i);
            step();
        end
        main_ev = 7'b1000000; step();
        main_ev = 7'b0100000; step();
        clr_main = 7'b0100000; step();

        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) == 0) main_ev = 7'($urandom & $urandom);
            if ($urandom_range(0, 2) == 0) err_ev = 6'($urandom & $urandom);
            if ($urandom_range(0, 1) == 0) clr_main = 7'($urandom);
            if ($urandom_range(0, 1) == 0) clr_err = 6'($urandom);
            if ($urandom_range(0, 3) == 0) main_hold = 7'($urandom);
            if ($urandom_range(0, 3) == 0) err_hold = 6'($urandom);
            if ($urandom_range(0, 15) == 0) begin
                en_we    = 1'b1;
                en_wdata = 8'($urandom);
            end
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule